// File: doc/BRIEF.md
# Seed Loader with 32-to-64-bit Packing

This block prepares the initial state of a lagged-Fibonacci random number engine. A host pushes 32-bit seed halves into a seed memory. That memory has a 32-bit write side and a 64-bit read side. A single address bit picks which four byte lanes of the 64-bit storage word a host write lands in, so two host writes fill one 64-bit seed.

After seeding, a start request arms a copy controller. The copy begins only when all three of these hold:
- the upstream stage reports seeds present (local enable);
- the host-side global enable is high;
- the select line from the downstream read controller is low.

The controller then streams the requested number of 64-bit seed words into two working memories at matching word indices. It raises load-done once the last write has landed. Load-done enables the next controller in the chain.

The controller is a five-state machine:
- `LD_IDLE`: after reset. A start request moves it to `LD_ARM`.
- `LD_ARM`: waits for the enables and a low select. A zero length then goes to `LD_DONE`; any other length goes to `LD_COPY`.
- `LD_COPY`: issues one seed read per cycle while both enables are high. It holds still when either enable is low. After issuing the last index it moves to `LD_DRAIN`.
- `LD_DRAIN`: lets the final delayed write complete, then moves to `LD_DONE`.
- `LD_DONE`: drives load-done. A start request returns it to `LD_ARM`.

The seed memory returns read data one cycle after the address. Because of that, write index and write enable toward the working memories trail the read by one register stage. Lengths above the memory depth are clamped to the depth.

Top module: `seed_loader`

## Requirements
- R1: After reset, load_done is low. No working-memory write occurs while no start request has been made, even with both enables high and select low.
- R2: A host write with address bit 3 equal to 0 updates byte lanes 0..3 (bits 31:0) of the addressed seed word. Bits 63:32 keep their value.
- R3: A host write with address bit 3 equal to 1 updates byte lanes 4..7 (bits 63:32) of the addressed seed word. Bits 31:0 keep their value.
- R4: The word index of every memory access is address bits 13:4. Address bits 2:0 have no effect.
- R5: After a start request, no copy takes place and load_done stays low while select is high, seeds_ready is low, or glb_en is low.
- R6: A copy of length N writes seed words 0..N-1 to the same indices of both working memories, with identical 64-bit data.
- R7: If glb_en or seeds_ready drops during a copy, the copy pauses and load_done stays low. It resumes when both return, and no word is lost or altered.
- R8: load_done rises after the last write of a copy. It stays high while no new start arrives. It is low on the cycle after a start request is accepted.
- R9: A start with length zero reaches load_done with no working-memory write.
- R10: The working-memory read side returns data one cycle after the address is sampled with wk_rd_en high. With wk_rd_en low, the output holds.
- R11: Working-memory words at index N and above are unchanged by a copy of length N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the controller |
| glb_en | input | 1 | Global enable from the host |
| host_wr_en | input | 1 | Host seed write strobe |
| host_addr | input | 14 | Host byte address; bit 3 selects the half, bits 13:4 the word |
| host_wdata | input | 32 | Host seed half-word |
| seeds_ready | input | 1 | Local enable: seeds present in the seed memory |
| rd_sel | input | 1 | Select from the read controller; copying starts only while low |
| start | input | 1 | Start request pulse; latches copy_len |
| copy_len | input | 11 | Number of 64-bit words to copy (clamped to 1024) |
| wk_rd_en | input | 1 | Read enable of both working memories |
| wk_rd_addr | input | 14 | Working-memory read byte address; bits 13:4 index the word |
| wk0_rd_data | output | 64 | Registered read data of working memory 0 |
| wk1_rd_data | output | 64 | Registered read data of working memory 1 |
| load_done | output | 1 | Copy-complete flag |

## Verification
On every cycle, assertions check four properties of the controller:
- a copy only leaves `LD_ARM` with both enables high and select low;
- the copy index freezes while an enable is missing;
- every working write targets an index below the latched length;
- the write count equals that length when load-done rises, and load-done holds until a start arrives.

A further assertion holds each host write to exactly one four-lane half. Only the directed scenarios can show that the packed data is correct, that untouched halves and words keep their value, that paused copies resume without corruption, and that the read side registers and holds. Those scenarios read the data back through the working-memory port.

// File: rtl/seed_loader_pkg.sv
package seed_loader_pkg;

    typedef enum logic [2:0] {
        LD_IDLE,
        LD_ARM,
        LD_COPY,
        LD_DRAIN,
        LD_DONE
    } ld_state_e;

    localparam int HALF_BYTES = 4;

endpackage

// File: rtl/lane_ram.sv
module lane_ram #(
    parameter int IDX_W  = 10,
    parameter int DATA_W = 64,
    localparam int NB    = DATA_W / 8,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              wr_pe,
    input  logic              wr_we,
    input  logic [NB-1:0]     wr_be,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_pe,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic [7:0] cells [DEPTH];
        logic [7:0] q;

        always_ff @(posedge clk) begin
            if (wr_pe && wr_we && wr_be[g]) begin
                cells[wr_idx] <= wr_data[g*8 +: 8];
            end
        end

        always_ff @(posedge clk) begin
            if (rd_pe) begin
                q <= cells[rd_idx];
            end
        end

        assign rd_data[g*8 +: 8] = q;
    end

endmodule

// File: rtl/seed_pack_mem.sv
module seed_pack_mem
    import seed_loader_pkg::*;
#(
    parameter int ADDR_W   = 14,
    parameter int HALF_BIT = 3,
    parameter int WORD_LSB = 4,
    localparam int IDX_W   = ADDR_W - WORD_LSB,
    localparam int HW      = HALF_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [HW-1:0]     host_wdata,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [2*HW-1:0]   rd_data
);

    logic [2*HALF_BYTES-1:0] lane_be;
    logic [2*HW-1:0]         wide_data;
    logic [IDX_W-1:0]        wr_idx;
    logic                    unused_addr_bits;

    always_comb begin
        if (host_addr[HALF_BIT]) begin
            lane_be = {{HALF_BYTES{1'b1}}, {HALF_BYTES{1'b0}}};
        end else begin
            lane_be = {{HALF_BYTES{1'b0}}, {HALF_BYTES{1'b1}}};
        end
    end

    assign wide_data        = {host_wdata, host_wdata};
    assign wr_idx           = host_addr[ADDR_W-1:WORD_LSB];
    assign unused_addr_bits = ^host_addr[HALF_BIT-1:0];

    lane_ram #(
        .IDX_W (IDX_W),
        .DATA_W(2 * HW)
    ) u_store (
        .clk    (clk),
        .wr_pe  (host_wr_en),
        .wr_we  (host_wr_en),
        .wr_be  (lane_be),
        .wr_idx (wr_idx),
        .wr_data(wide_data),
        .rd_pe  (rd_en),
        .rd_idx (rd_idx),
        .rd_data(rd_data)
    );

    // One host write touches exactly one half of the word.
    assert_one_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr_en |-> ($countones(lane_be) == HALF_BYTES) &&
                       ((lane_be[HALF_BYTES-1:0] == '0) || (lane_be[2*HALF_BYTES-1:HALF_BYTES] == '0)));

endmodule

// File: rtl/seed_copy_ctrl.sv
module seed_copy_ctrl
    import seed_loader_pkg::*;
#(
    parameter int IDX_W  = 10,
    parameter int DATA_W = 64,
    localparam int LEN_W = IDX_W + 1,
    localparam int NB    = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  len,
    input  logic              local_en,
    input  logic              glb_en,
    input  logic              rd_sel,
    output logic              seed_rd_en,
    output logic [IDX_W-1:0]  seed_rd_idx,
    input  logic [DATA_W-1:0] seed_q,
    output logic              wk_pe,
    output logic              wk_we,
    output logic [NB-1:0]     wk_be,
    output logic [IDX_W-1:0]  wk_idx,
    output logic [DATA_W-1:0] wk_data,
    output logic              load_done
);

    localparam logic [LEN_W-1:0] DEPTH = LEN_W'(1 << IDX_W);

    ld_state_e        state, nxt;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] idx;
    logic             pend;
    logic [IDX_W-1:0] wr_idx_q;
    logic             go;
    logic             accept;
    logic             last;

    assign go     = local_en && glb_en;
    assign accept = start && ((state == LD_IDLE) || (state == LD_DONE));
    assign last   = (idx == LEN_W'(len_q - 1'b1));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= LD_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            LD_IDLE: if (start) nxt = LD_ARM;
            LD_ARM: begin
                if (go && !rd_sel) begin
                    nxt = (len_q == '0) ? LD_DONE : LD_COPY;
                end
            end
            LD_COPY:  if (go && last) nxt = LD_DRAIN;
            LD_DRAIN: nxt = LD_DONE;
            LD_DONE:  if (start) nxt = LD_ARM;
            default:  nxt = LD_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        seed_rd_en = (state == LD_COPY) && go;
        load_done  = (state == LD_DONE);
        wk_pe      = pend;
        wk_we      = pend;
        wk_be      = pend ? {NB{1'b1}} : {NB{1'b0}};
    end

    // Index and write-alignment registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q    <= '0;
            idx      <= '0;
            pend     <= 1'b0;
            wr_idx_q <= '0;
        end else begin
            pend <= seed_rd_en;
            if (accept) begin
                len_q <= (len > DEPTH) ? DEPTH : len;
                idx   <= '0;
            end else if (seed_rd_en) begin
                idx      <= idx + 1'b1;
                wr_idx_q <= idx[IDX_W-1:0];
            end
        end
    end

    assign seed_rd_idx = idx[IDX_W-1:0];
    assign wk_idx      = wr_idx_q;
    assign wk_data     = seed_q;

    // Write counter used only by the checks below
    logic [LEN_W-1:0] wr_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_cnt <= '0;
        end else if (accept) begin
            wr_cnt <= '0;
        end else if (wk_we) begin
            wr_cnt <= wr_cnt + 1'b1;
        end
    end

    assert_arm_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LD_COPY && $past(state) == LD_ARM) |-> $past(glb_en && local_en && !rd_sel));

    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LD_COPY && !(glb_en && local_en)) |=> $stable(idx));

    assert_wr_in_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wk_we |-> ({1'b0, wk_idx} < len_q));

    assert_done_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_done) |-> (wr_cnt == len_q));

    assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_done && !start) |=> load_done);

endmodule

// File: rtl/seed_loader.sv
module seed_loader
    import seed_loader_pkg::*;
#(
    parameter int ADDR_W   = 14,
    parameter int HALF_BIT = 3,
    parameter int WORD_LSB = 4,
    parameter int NUM_WORK = 2,
    localparam int IDX_W   = ADDR_W - WORD_LSB,
    localparam int HW      = HALF_BYTES * 8,
    localparam int DW      = 2 * HW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              glb_en,
    input  logic              host_wr_en,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [HW-1:0]     host_wdata,
    input  logic              seeds_ready,
    input  logic              rd_sel,
    input  logic              start,
    input  logic [IDX_W:0]    copy_len,
    input  logic              wk_rd_en,
    input  logic [ADDR_W-1:0] wk_rd_addr,
    output logic [DW-1:0]     wk0_rd_data,
    output logic [DW-1:0]     wk1_rd_data,
    output logic              load_done
);

    logic             seed_rd_en;
    logic [IDX_W-1:0] seed_rd_idx;
    logic [DW-1:0]    seed_q;
    logic             wk_pe;
    logic             wk_we;
    logic [DW/8-1:0]  wk_be;
    logic [IDX_W-1:0] wk_idx;
    logic [DW-1:0]    wk_data;
    logic [DW-1:0]    wk_q [NUM_WORK];
    logic             unused_rd_addr_bits;

    assign unused_rd_addr_bits = ^wk_rd_addr[WORD_LSB-1:0];

    seed_pack_mem #(
        .ADDR_W  (ADDR_W),
        .HALF_BIT(HALF_BIT),
        .WORD_LSB(WORD_LSB)
    ) u_seed (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_wr_en(host_wr_en),
        .host_addr (host_addr),
        .host_wdata(host_wdata),
        .rd_en     (seed_rd_en),
        .rd_idx    (seed_rd_idx),
        .rd_data   (seed_q)
    );

    seed_copy_ctrl #(
        .IDX_W (IDX_W),
        .DATA_W(DW)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .len        (copy_len),
        .local_en   (seeds_ready),
        .glb_en     (glb_en),
        .rd_sel     (rd_sel),
        .seed_rd_en (seed_rd_en),
        .seed_rd_idx(seed_rd_idx),
        .seed_q     (seed_q),
        .wk_pe      (wk_pe),
        .wk_we      (wk_we),
        .wk_be      (wk_be),
        .wk_idx     (wk_idx),
        .wk_data    (wk_data),
        .load_done  (load_done)
    );

    for (genvar g = 0; g < NUM_WORK; g++) begin : g_work
        lane_ram #(
            .IDX_W (IDX_W),
            .DATA_W(DW)
        ) u_work (
            .clk    (clk),
            .wr_pe  (wk_pe),
            .wr_we  (wk_we),
            .wr_be  (wk_be),
            .wr_idx (wk_idx),
            .wr_data(wk_data),
            .rd_pe  (wk_rd_en),
            .rd_idx (wk_rd_addr[ADDR_W-1:WORD_LSB]),
            .rd_data(wk_q[g])
        );
    end

    assign wk0_rd_data = wk_q[0];
    assign wk1_rd_data = wk_q[1];

endmodule

// File: tb/seed_loader_test.sv
module seed_loader_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        glb_en;
    logic        host_wr_en;
    logic [13:0] host_addr;
    logic [31:0] host_wdata;
    logic        seeds_ready;
    logic        rd_sel;
    logic        start;
    logic [10:0] copy_len;
    logic        wk_rd_en;
    logic [13:0] wk_rd_addr;
    logic [63:0] wk0_rd_data;
    logic [63:0] wk1_rd_data;
    logic        load_done;

    int checks = 0;
    int errors = 0;
    logic [63:0] exp_seed [16];
    logic [63:0] exp_wk   [16];

    always #10 clk = ~clk;

    seed_loader uut (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .host_wr_en(host_wr_en),
        .host_addr(host_addr), .host_wdata(host_wdata), .seeds_ready(seeds_ready),
        .rd_sel(rd_sel), .start(start), .copy_len(copy_len), .wk_rd_en(wk_rd_en),
        .wk_rd_addr(wk_rd_addr), .wk0_rd_data(wk0_rd_data), .wk1_rd_data(wk1_rd_data),
        .load_done(load_done)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic host_write(input int word, input bit upper, input logic [2:0] low_bits, input logic [31:0] d);
        host_wr_en = 1'b1;
        host_addr  = {word[9:0], upper, low_bits};
        host_wdata = d;
        tick();
        host_wr_en = 1'b0;
        if (upper) exp_seed[word][63:32] = d;
        else       exp_seed[word][31:0]  = d;
    endtask

    task automatic read_work(input int word, input logic [3:0] low_bits, output logic [63:0] d0, output logic [63:0] d1);
        wk_rd_en   = 1'b1;
        wk_rd_addr = {word[9:0], low_bits};
        tick();
        wk_rd_en = 1'b0;
        d0 = wk0_rd_data;
        d1 = wk1_rd_data;
    endtask

    task automatic check_word(input int word, input string req);
        logic [63:0] d0, d1;
        read_work(word, 4'h0, d0, d1);
        check(d0 === exp_wk[word], req, d0, exp_wk[word]);
        check(d1 === exp_wk[word], req, d1, exp_wk[word]);
    endtask

    task automatic pulse_start(input int len);
        start    = 1'b1;
        copy_len = len[10:0];
        tick();
        start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        bit seen = 1'b0;
        for (int i = 0; i < 300; i++) begin
            if (load_done) begin
                seen = 1'b1;
                break;
            end
            tick();
        end
        check(seen, req, {63'd0, load_done}, 64'd1);
    endtask

    task automatic model_copy(input int len);
        for (int i = 0; i < len; i++) exp_wk[i] = exp_seed[i];
    endtask

    // R1: reset and no activity without a start
    task automatic t_reset();
        check(load_done === 1'b0, "R1 reset", {63'd0, load_done}, 64'd0);
        glb_en = 1'b1; seeds_ready = 1'b1; rd_sel = 1'b0;
        repeat (4) tick();
        check(load_done === 1'b0, "R1 idle without start", {63'd0, load_done}, 64'd0);
    endtask

    // R2 R3 R4: packing into halves, then a full copy shows it (R6, R8)
    task automatic t_pack_and_copy();
        for (int w = 0; w < 8; w++) begin
            host_write(w, 1'b0, 3'd0, 32'h1000_0000 + w);
            host_write(w, 1'b1, 3'd0, 32'hA000_0000 + w);
        end
        host_write(2, 1'b0, 3'd0, 32'hDEAD_0002);
        host_write(3, 1'b1, 3'd5, 32'hBEEF_0003);
        pulse_start(8);
        wait_done("R6 copy of 8 done");
        model_copy(8);
        for (int w = 0; w < 8; w++) check_word(w, "R6 copied word");
        check(exp_wk[2] == 64'hA000_0002_DEAD_0002, "R2 low half only", exp_wk[2], 64'hA000_0002_DEAD_0002);
        check(exp_wk[3] == 64'hBEEF_0003_1000_0003, "R3 R4 upper half with low bits", exp_wk[3], 64'hBEEF_0003_1000_0003);
        check(load_done === 1'b1, "R8 done holds", {63'd0, load_done}, 64'd1);
    endtask

    // R10: registered read side holds with enable low
    task automatic t_read_port();
        logic [63:0] d0, d1;
        read_work(5, 4'h9, d0, d1);
        check(d0 === exp_wk[5], "R10 read with low addr bits", d0, exp_wk[5]);
        wk_rd_addr = 14'h0010;
        tick();
        check(wk0_rd_data === exp_wk[5], "R10 hold when disabled", wk0_rd_data, exp_wk[5]);
        check(wk1_rd_data === exp_wk[5], "R10 hold when disabled", wk1_rd_data, exp_wk[5]);
    endtask

    // R5 gating, R11 untouched upper words, R8 start clears done
    task automatic t_gate();
        host_write(0, 1'b0, 3'd0, 32'h5555_0000);
        host_write(1, 1'b1, 3'd0, 32'h6666_0001);
        rd_sel = 1'b1;
        pulse_start(2);
        check(load_done === 1'b0, "R8 start clears done", {63'd0, load_done}, 64'd0);
        repeat (8) tick();
        check(load_done === 1'b0, "R5 select high blocks", {63'd0, load_done}, 64'd0);
        check_word(0, "R5 no copy while select high");
        rd_sel = 1'b0; seeds_ready = 1'b0;
        repeat (6) tick();
        check(load_done === 1'b0, "R5 seeds absent blocks", {63'd0, load_done}, 64'd0);
        check_word(1, "R5 no copy while seeds absent");
        seeds_ready = 1'b1;
        wait_done("R5 copy after release");
        model_copy(2);
        for (int w = 0; w < 8; w++) check_word(w, "R11 copy of 2");
    endtask

    // R7: pause mid-copy
    task automatic t_pause();
        for (int w = 0; w < 6; w++) host_write(w, w[0], 3'd0, 32'h7700_0000 + w);
        pulse_start(6);
        tick(); tick();
        glb_en = 1'b0;
        repeat (6) tick();
        check(load_done === 1'b0, "R7 paused", {63'd0, load_done}, 64'd0);
        glb_en = 1'b1;
        wait_done("R7 resumes");
        model_copy(6);
        for (int w = 0; w < 8; w++) check_word(w, "R7 R11 after pause");
    endtask

    // R9: zero length
    task automatic t_zero();
        host_write(0, 1'b0, 3'd0, 32'h9999_9999);
        pulse_start(0);
        tick();
        check(load_done === 1'b1, "R9 zero length done", {63'd0, load_done}, 64'd1);
        check_word(0, "R9 no write on zero length");
    endtask

    initial begin
        for (int w = 0; w < 16; w++) begin
            exp_seed[w] = '0;
            exp_wk[w]   = '0;
        end
        rst_n = 1'b0; glb_en = 1'b0; host_wr_en = 1'b0; host_addr = '0; host_wdata = '0;
        seeds_ready = 1'b0; rd_sel = 1'b0; start = 1'b0; copy_len = '0;
        wk_rd_en = 1'b0; wk_rd_addr = '0;
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_pack_and_copy();
        t_read_port();
        t_gate();
        t_pause();
        t_zero();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule